// File: doc/BRIEF.md
# UART Transmit Status and Holding-Empty Interrupt

This block keeps the transmit half of the line status for one serial channel. Characters written by the host go into a single holding register or, when the FIFO mode is on, into a 16-entry first-in-first-out store. A separate shift register, outside this block, takes characters one at a time with a load strobe and reports the end of each final stop bit with a done strobe. From this traffic the block derives two status flags. The holding-empty flag is set while no character waits to be shifted. The transmitter-empty flag is set only when nothing waits and the shift register is also idle.

The block also raises the transmitter-holding-empty interrupt request when its enable is set. An outside priority arbiter tells the block whether it is the source reported in the identification register. A read of that register, made while this source is the reported one, clears the request. A host write also clears it, because the storage is then no longer empty. Changing the FIFO mode flushes the store, as it does on a 16550-class channel.

Top module: `uart_tx_status`

## Requirements
- R1: After reset, holdEmpty = 1, txEmpty = 1, txIrq = 0 and txAvail = 0.
- R2: With fifoMode = 0, storage is one character deep. A write while it is occupied replaces the waiting character without any load, and txData shows the newest one.
- R3: With fifoMode = 1, up to 16 characters are held and sent to txData in write order. A write that finds 16 stored, with no load in the same cycle, is dropped.
- R4: holdEmpty is 1 exactly when no character is stored. It falls on the clock edge that takes a write and rises on the edge whose load takes the last stored character.
- R5: txEmpty is 1 only while holdEmpty is 1 and the shift register is idle. A load marks the shift register busy until a later shiftDone.
- R6: A write in the same cycle as a load that takes the last stored character keeps holdEmpty at 0 and txEmpty at 0 with no one-cycle pulse.
- R7: One edge after holdEmpty rises with thrIntEn = 1, txIrq goes to 1. txIrq is never 1 while thrIntEn = 0, and dropping thrIntEn discards the pending request.
- R8: An identification read (iirRead = 1) clears a pending request only when iirSelThre = 1. With iirSelThre = 0 the request stays.
- R9: An accepted host write clears a pending request on the same edge, and it wins over a set in that edge.
- R10: A 0-to-1 change of thrIntEn while holdEmpty = 1 raises txIrq on that edge.
- R11: The edge after fifoMode changes empties the storage, and a write in that cycle is dropped. The shift register state is kept.
- R12: shiftLoad with nothing stored has no effect. shiftDone while the shift register is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoMode | input | 1 | 1 = 16-entry FIFO, 0 = single holding register |
| hostWrite | input | 1 | Host write strobe for the holding register or FIFO |
| hostData | input | 8 | Character written by the host |
| shiftLoad | input | 1 | Shift register takes the character on txData |
| shiftDone | input | 1 | Shift register finished the final stop bit |
| thrIntEn | input | 1 | Holding-empty interrupt enable |
| iirRead | input | 1 | Host reads the interrupt identification register |
| iirSelThre | input | 1 | Arbiter reports this source as the identified one |
| txData | output | 8 | Oldest stored character |
| txAvail | output | 1 | At least one character stored |
| holdEmpty | output | 1 | Holding-empty status flag |
| txEmpty | output | 1 | Transmitter-empty status flag |
| txIrq | output | 1 | Holding-empty interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first is a host write together with a load that empties the storage. The second is a host write together with an event that would set the interrupt: the edge after holdEmpty rises, or an enable rise. Directed sequences force each pair at the one-character boundary in both modes. Long random runs with high write and load rates make them occur often. A behavioural reference, built from a byte queue and a few flags, is compared every cycle, so a transient pulse on either empty flag or a lost or extra interrupt shows up as a mismatch on the cycle where it happens.

// File: rtl/uart_tx_status_pkg.sv
package uart_tx_status_pkg;

  // strobes from the control to the storage datapath, one cycle each
  typedef struct packed {
    logic push;      // store hostData
    logic pop;       // head moves to the shift register
    logic overwrite; // replace the head in place (holding mode, occupied)
    logic flush;     // discard all stored characters
    logic shiftEnd;  // shift register finished its character
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_status_data.sv
module uart_tx_status_data
  import uart_tx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic              empty,
  output logic              full,
  output logic              shiftBusy
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP_FIFO = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_HOLD = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr, wrSlot;
  logic [CNT_W-1:0]  count;
  logic              advanceWr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign advanceWr = strb.push && !strb.overwrite;
  assign wrSlot    = strb.overwrite ? rdPtr : wrPtr;

  // one register per slot; only the addressed slot loads
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strb.push && (wrSlot == PTR_W'(g))) slotQ[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strb.pop)  rdPtr <= bump(rdPtr);
      if (advanceWr) wrPtr <= bump(wrPtr);
      case ({advanceWr, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // the shift register is busy from a load until its done strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftBusy <= 1'b0;
    else if (strb.pop)      shiftBusy <= 1'b1;
    else if (strb.shiftEnd) shiftBusy <= 1'b0;
  end

  assign headData = slotQ[rdPtr];
  assign empty    = (count == '0);
  assign full     = (count == (fifoMode ? CAP_FIFO : CAP_HOLD));

endmodule

// File: rtl/uart_tx_status_ctrl.sv
module uart_tx_status_ctrl
  import uart_tx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoMode,
  input  logic      hostWrite,
  input  logic      shiftLoad,
  input  logic      shiftDone,
  input  logic      thrIntEn,
  input  logic      iirRead,
  input  logic      iirSelThre,
  input  logic      empty,
  input  logic      full,
  output txStrobe_t strb,
  output logic      txIrq
);

  logic modeQ;   // fifoMode seen last cycle
  logic emptyQ;  // empty flag seen last cycle
  logic enQ;     // enable seen last cycle
  logic pendQ;   // pending holding-empty request
  logic pendNext;
  logic modeChange, emptyRise, enRise, iirClear;

  assign modeChange = (fifoMode != modeQ);
  assign emptyRise  = empty && !emptyQ;
  assign enRise     = thrIntEn && !enQ;
  assign iirClear   = iirRead && iirSelThre;

  always_comb begin
    strb           = '0;
    strb.flush     = modeChange;
    strb.pop       = shiftLoad && !empty && !modeChange;
    strb.push      = hostWrite && !modeChange && (!fifoMode || !full || strb.pop);
    strb.overwrite = strb.push && full && !strb.pop;
    strb.shiftEnd  = shiftDone;
  end

  // priority: disabled, then write, then new empty event, then id read
  always_comb begin
    if (!thrIntEn)                    pendNext = 1'b0;
    else if (strb.push)               pendNext = 1'b0;
    else if (emptyRise)               pendNext = 1'b1;
    else if (enRise && empty)         pendNext = 1'b1;
    else if (iirClear)                pendNext = 1'b0;
    else                              pendNext = pendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      emptyQ <= 1'b1;
      enQ    <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      modeQ  <= fifoMode;
      emptyQ <= empty;
      enQ    <= thrIntEn;
      pendQ  <= pendNext;
    end
  end

  assign txIrq = pendQ && thrIntEn;

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
  import uart_tx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              hostWrite,
  input  logic [DATA_W-1:0] hostData,
  input  logic              shiftLoad,
  input  logic              shiftDone,
  input  logic              thrIntEn,
  input  logic              iirRead,
  input  logic              iirSelThre,
  output logic [DATA_W-1:0] txData,
  output logic              txAvail,
  output logic              holdEmpty,
  output logic              txEmpty,
  output logic              txIrq
);

  txStrobe_t strb;
  logic      empty, full, shiftBusy;

  uart_tx_status_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fifoMode   (fifoMode),
    .hostWrite  (hostWrite),
    .shiftLoad  (shiftLoad),
    .shiftDone  (shiftDone),
    .thrIntEn   (thrIntEn),
    .iirRead    (iirRead),
    .iirSelThre (iirSelThre),
    .empty      (empty),
    .full       (full),
    .strb       (strb),
    .txIrq      (txIrq)
  );

  uart_tx_status_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .fifoMode  (fifoMode),
    .strb      (strb),
    .wrData    (hostData),
    .headData  (txData),
    .empty     (empty),
    .full      (full),
    .shiftBusy (shiftBusy)
  );

  assign txAvail   = !empty;
  assign holdEmpty = empty;
  assign txEmpty   = empty && !shiftBusy;

endmodule

// File: rtl/uart_tx_status_chk.sv
module uart_tx_status_chk
  import uart_tx_status_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      thrIntEn,
  input logic      iirRead,
  input logic      iirSelThre,
  input logic      holdEmpty,
  input logic      txEmpty,
  input logic      txIrq,
  input txStrobe_t strb
);

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty); // R5

  AST_PUSH_DROPS_THRE: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> !holdEmpty); // R4

  AST_POP_DROPS_TEMT: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> !txEmpty); // R5

  AST_SAME_CYCLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.pop) |=> (!holdEmpty && !txEmpty)); // R6

  AST_IRQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> holdEmpty); // R7

  AST_IIR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && iirRead && iirSelThre) |=> !txIrq); // R8

endmodule

bind uart_tx_status uart_tx_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .thrIntEn   (thrIntEn),
  .iirRead    (iirRead),
  .iirSelThre (iirSelThre),
  .holdEmpty  (holdEmpty),
  .txEmpty    (txEmpty),
  .txIrq      (txIrq),
  .strb       (strb)
);

// File: tb/test_uart_tx_status.sv
module test_uart_tx_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoMode = 1'b0, hostWrite = 1'b0, shiftLoad = 1'b0, shiftDone = 1'b0;
  logic       thrIntEn = 1'b0, iirRead = 1'b0, iirSelThre = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic [7:0] txData;
  logic       txAvail, holdEmpty, txEmpty, txIrq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  uart_tx_status i_uart_tx_status (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .hostWrite(hostWrite),
    .hostData(hostData), .shiftLoad(shiftLoad), .shiftDone(shiftDone),
    .thrIntEn(thrIntEn), .iirRead(iirRead), .iirSelThre(iirSelThre),
    .txData(txData), .txAvail(txAvail), .holdEmpty(holdEmpty),
    .txEmpty(txEmpty), .txIrq(txIrq)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] q[$];
  bit mBusy, mPend, mModeQ, mEmptyQ, mEnQ;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete(); mBusy = 0; mPend = 0; mModeQ = 0; mEmptyQ = 1; mEnQ = 0;
    end else begin
      bit flush, pop, push, isFull, emptyNow;
      int cap;
      emptyNow = (q.size() == 0);
      cap    = fifoMode ? 16 : 1;
      isFull = (q.size() >= cap);
      flush  = (fifoMode != mModeQ);
      pop    = shiftLoad && !emptyNow && !flush;
      push   = hostWrite && !flush && (!fifoMode || !isFull || pop);
      if (!thrIntEn) mPend = 0;
      else if (push) mPend = 0;
      else if (emptyNow && !mEmptyQ) mPend = 1;
      else if (!mEnQ && emptyNow) mPend = 1;
      else if (iirRead && iirSelThre) mPend = 0;
      if (flush) q.delete();
      else begin
        if (pop) void'(q.pop_front());
        if (push) begin
          if (isFull && !pop) q[0] = hostData;
          else q.push_back(hostData);
        end
      end
      if (pop) mBusy = 1; else if (shiftDone) mBusy = 0;
      mEmptyQ = emptyNow; mEnQ = thrIntEn; mModeQ = fifoMode;
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    bit e;
    e = (q.size() == 0);
    chk("R4 holdEmpty vs model", holdEmpty, e);
    chk("R5 txEmpty vs model", txEmpty, e && !mBusy);
    chk("R7 txIrq vs model", txIrq, mPend && thrIntEn);
    chk("R12 txAvail vs model", txAvail, !e);
    if (!e) chk("R3 txData vs model", txData, q[0]);
  endtask

  // apply inputs for one edge, then compare at the following negedge
  task automatic tick(bit w, logic [7:0] d, bit ld, bit dn, bit rd = 0, bit sel = 0);
    hostWrite = w; hostData = d; shiftLoad = ld; shiftDone = dn;
    iirRead = rd; iirSelThre = sel;
    @(negedge clk);
    compareModel();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00, 0, 0);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 holdEmpty", holdEmpty, 1); chk("R1 txEmpty", txEmpty, 1);
    chk("R1 txIrq", txIrq, 0);         chk("R1 txAvail", txAvail, 0);
    rstN = 1'b1;
    idle(2);

    // R2 holding register overwrite
    tick(1, 8'hA5, 0, 0);
    chk("R4 falls after write", holdEmpty, 0);
    tick(1, 8'h3C, 0, 0);
    chk("R2 newest char", txData, 8'h3C);
    tick(0, 8'h00, 1, 0);
    chk("R4 rises after last load", holdEmpty, 1);
    chk("R5 busy keeps txEmpty low", txEmpty, 0);
    idle(2);
    chk("R5 still low until done", txEmpty, 0);
    tick(0, 8'h00, 0, 1);
    chk("R5 high after done", txEmpty, 1);

    // R12 ignored strobes
    tick(0, 8'h00, 1, 0);
    chk("R12 load when empty", txEmpty, 1);
    tick(0, 8'h00, 0, 1);
    chk("R12 done when idle", txEmpty, 1);

    // R10 enable rise while empty
    thrIntEn = 1;
    tick(0, 8'h00, 0, 0);
    chk("R10 enable rise raises irq", txIrq, 1);
    // R8 id read
    tick(0, 8'h00, 0, 0, 1, 0);
    chk("R8 read not selected keeps", txIrq, 1);
    tick(0, 8'h00, 0, 0, 1, 1);
    chk("R8 selected read clears", txIrq, 0);

    // R7 empty transition
    tick(1, 8'h11, 0, 0);
    tick(0, 8'h00, 1, 0);
    chk("R7 one-edge lag", txIrq, 0);
    tick(0, 8'h00, 0, 1);
    chk("R7 irq after empty rise", txIrq, 1);
    tick(1, 8'h22, 0, 0);
    chk("R9 write clears irq", txIrq, 0);
    // R6 write with last load
    tick(1, 8'h33, 1, 0);
    chk("R6 holdEmpty stays low", holdEmpty, 0);
    chk("R6 txEmpty stays low", txEmpty, 0);
    chk("R6 next char", txData, 8'h33);
    tick(0, 8'h00, 0, 1);
    chk("R6 no irq", txIrq, 0);
    tick(0, 8'h00, 1, 0);
    thrIntEn = 0;
    tick(0, 8'h00, 0, 0);
    chk("R7 disabled no irq", txIrq, 0);
    thrIntEn = 1;
    tick(1, 8'h44, 0, 0);
    chk("R9 write wins over enable rise", txIrq, 0);

    // R11 mode change flushes
    fifoMode = 1;
    tick(1, 8'h55, 0, 0);
    chk("R11 flushed", holdEmpty, 1);
    chk("R11 write dropped", txAvail, 0);
    tick(0, 8'h00, 0, 1);

    // R3 fill sixteen plus one
    for (int i = 0; i < 17; i++) tick(1, 8'(i + 8'h60), 0, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R3 order", txData, i + 8'h60);
      tick(0, 8'h00, 1, 1);
    end
    chk("R3 17th dropped", holdEmpty, 1);
    idle(2);

    // random patterns, three rate profiles
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 3000; c++) begin
        int wr, ld;
        wr = (p == 0) ? 30 : (p == 1) ? 70 : 15;
        ld = (p == 0) ? 30 : (p == 1) ? 20 : 60;
        if ($urandom_range(0, 99) < 3) thrIntEn = ~thrIntEn;
        if ($urandom_range(0, 299) == 0) fifoMode = ~fifoMode;
        tick($urandom_range(0, 99) < wr, 8'($urandom), $urandom_range(0, 99) < ld,
             $urandom_range(0, 99) < 25, $urandom_range(0, 99) < 15, $urandom_range(0, 1) == 1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule